// File: doc/BRIEF.md
# LFSR Noise Channel

This block produces a pseudo-random one-bit noise voice for a sound unit. A down-counting timer, stepped once per CPU clock, fires a shift pulse at an interval picked from a fixed sixteen-entry table of CPU-clock counts. Each pulse advances a 15-bit linear feedback shift register, and a mode flag picks which register bit feeds back: one choice gives a long maximal sequence, the other a short buzzy loop.

The envelope generator, length counter and mixer sit outside the block. They supply a 4-bit volume and a "length still running" flag. The block passes that volume out as its sample, or forces the sample to zero, depending on the low register bit and on the length flag. Software reaches the block through one write-only configuration byte. The sample is a level that can be read on any clock, not a stream of items, so it has no valid/ready handshake and the sink never back-pressures it.

Top module: `noise_channel`

## Requirements
- R1: While reset is held and on the first clock after it, the shift register holds 1, the mode is long, the period index is 0 and the timer count is 0. The sample is therefore 0 while reset is held.
- R2: A clock with `cfg_we` high loads `cfg_byte[7]` as the mode flag (1 = short) and `cfg_byte[3:0]` as the period index. Bits 6 to 4 are ignored.
- R3: Period index 0..15 maps to shift intervals of 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034 and 4068 clocks. The timer counts down once per clock. When it is at 0 it issues a shift pulse and reloads with the interval minus one. Its count after reset is 0.
- R4: On a shift pulse the feedback is bit 0 XOR bit 1 in long mode, or bit 0 XOR bit 6 in short mode. The register shifts right by one and the feedback enters bit 14. Without a pulse the register holds its value.
- R5: In long mode the bit-0 sequence repeats every 32767 shifts, and the register never reaches all zeros, so bit 0 is never low for more than 14 shifts in a row.
- R6: In short mode the bit-0 sequence repeats every 93 shifts. Depending on the register state the loop is 93 or 31 steps long.
- R7: `sample` equals `volume` when register bit 0 is 0 and `len_active` is 1. Otherwise it is 0.
- R8: A new period index takes effect only at the next timer reload. The count already under way finishes with its old length.
- R9: Writing the mode flag leaves the shift register contents unchanged. Only later shifts use the new tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; one edge is one CPU cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_byte | input | 8 | Bit 7 mode flag, bits 3:0 period index |
| volume | input | 4 | Volume from the external envelope generator |
| len_active | input | 1 | High while the external length counter is nonzero |
| sample | output | 4 | Gated volume toward the mixer |

## Verification
The bench builds the block with its default parameters: a 15-bit register, taps at bits 1 and 6, and a 4-bit volume. With these values the full 32767-shift long cycle fits in the run at the shortest interval of four clocks. A reference model predicts the sample on every clock. The bench sweeps all sixteen table intervals, writes the mode and period mid-count, toggles the gating inputs, and checks the repeat lengths of the long and short sequences using the bit-0 values it reads back through the sample.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int IDX_W = 4;
  localparam int CNT_W = 12;

  typedef struct packed {
    logic             short_mode;
    logic [IDX_W-1:0] idx;
  } noise_cfg_t;

  function automatic logic [CNT_W-1:0] shift_interval(input logic [IDX_W-1:0] i);
    logic [CNT_W-1:0] v;
    case (i)
      4'd0:  v = 12'd4;
      4'd1:  v = 12'd8;
      4'd2:  v = 12'd16;
      4'd3:  v = 12'd32;
      4'd4:  v = 12'd64;
      4'd5:  v = 12'd96;
      4'd6:  v = 12'd128;
      4'd7:  v = 12'd160;
      4'd8:  v = 12'd202;
      4'd9:  v = 12'd254;
      4'd10: v = 12'd380;
      4'd11: v = 12'd508;
      4'd12: v = 12'd762;
      4'd13: v = 12'd1016;
      4'd14: v = 12'd2034;
      default: v = 12'd4068;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/noise_cfg_reg.sv
module noise_cfg_reg
  import noise_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int MODE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output noise_cfg_t        cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      cfg.short_mode <= wdata[MODE_BIT];
      cfg.idx        <= wdata[IDX_W-1:0];
    end
  end

  a_r2_write_load: assert property (@(posedge clk) disable iff (rst)
    we |=> (cfg.idx == $past(wdata[IDX_W-1:0])) && (cfg.short_mode == $past(wdata[MODE_BIT])));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg));
endmodule

// File: rtl/noise_period_timer.sv
module noise_period_timer
  import noise_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) cnt <= shift_interval(idx) - 1'b1;
    else cnt <= cnt - 1'b1;
  end

  a_r3_countdown: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  a_r8_reload_value: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == shift_interval($past(idx)) - 1'b1));
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int W         = 15,
  parameter int LONG_TAP  = 1,
  parameter int SHORT_TAP = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         short_mode,
  output logic [W-1:0] state
);
  logic         fb;
  logic [W-1:0] nxt;

  assign fb = state[0] ^ (short_mode ? state[SHORT_TAP] : state[LONG_TAP]);

  for (genvar g = 0; g < W - 1; g++) begin : g_shift
    assign nxt[g] = state[g+1];
  end
  assign nxt[W-1] = fb;

  always_ff @(posedge clk) begin
    if (rst) state <= {{(W-1){1'b0}}, 1'b1};
    else if (step) state <= nxt;
  end

  a_r4_shift_right: assert property (@(posedge clk) disable iff (rst)
    step |=> (state[W-2:0] == $past(state[W-1:1])));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));
  a_r5_never_zero: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/noise_gate.sv
module noise_gate #(
  parameter int VOL_W = 4
) (
  input  logic             low_bit,
  input  logic             len_active,
  input  logic [VOL_W-1:0] volume,
  output logic [VOL_W-1:0] sample
);
  always_comb begin
    sample = volume;
    if (low_bit || !len_active) sample = '0;
  end
endmodule

// File: rtl/noise_channel.sv
module noise_channel
  import noise_pkg::*;
#(
  parameter int LFSR_W    = 15,
  parameter int LONG_TAP  = 1,
  parameter int SHORT_TAP = 6,
  parameter int VOL_W     = 4,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [BYTE_W-1:0] cfg_byte,
  input  logic [VOL_W-1:0]  volume,
  input  logic              len_active,
  output logic [VOL_W-1:0]  sample
);
  localparam int MODE_BIT = BYTE_W - 1;

  noise_cfg_t        cfg;
  logic              tick;
  logic [LFSR_W-1:0] lfsr_q;

  noise_cfg_reg #(.BYTE_W(BYTE_W), .MODE_BIT(MODE_BIT)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_byte), .cfg(cfg));

  noise_period_timer u_timer (
    .clk(clk), .rst(rst), .idx(cfg.idx), .tick(tick));

  noise_lfsr #(.W(LFSR_W), .LONG_TAP(LONG_TAP), .SHORT_TAP(SHORT_TAP)) u_lfsr (
    .clk(clk), .rst(rst), .step(tick), .short_mode(cfg.short_mode), .state(lfsr_q));

  noise_gate #(.VOL_W(VOL_W)) u_gate (
    .low_bit(lfsr_q[0]), .len_active(len_active), .volume(volume), .sample(sample));

  a_r7_gate_zero: assert property (@(posedge clk) disable iff (rst)
    (sample != '0) |-> (!lfsr_q[0] && len_active));
  a_r9_mode_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !tick) |=> $stable(lfsr_q));
endmodule

// File: tb/test_noise_channel.sv
`timescale 1ns/1ps
module test_noise_channel;
  logic       clk = 0;
  logic       rst = 1;
  logic       cfg_we = 0;
  logic [7:0] cfg_byte = 0;
  logic [3:0] volume = 4'd9;
  logic       len_active = 1;
  logic [3:0] sample;

  noise_channel i_noise_channel (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_byte(cfg_byte),
    .volume(volume), .len_active(len_active), .sample(sample));

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";
  bit capturing = 0;
  bit obs_q[$];
  bit finished = 0;

  int tbl[16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068};

  // Reference model state, written from the requirements
  int          m_cnt;
  logic [14:0] m_lfsr;
  bit          m_short;
  int          m_idx;

  typedef struct { bit low; bit tick; } exp_t;
  exp_t exp_q[$];

  task automatic check(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Driver side: advance model at each edge, push expected item
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_lfsr = 15'd1; m_short = 0; m_idx = 0;
    end else begin
      bit t;
      bit fb;
      t = (m_cnt == 0);
      if (t) begin
        fb = m_lfsr[0] ^ (m_short ? m_lfsr[6] : m_lfsr[1]);
        m_lfsr = {fb, m_lfsr[14:1]};
        m_cnt = tbl[m_idx] - 1;
      end else begin
        m_cnt = m_cnt - 1;
      end
      if (cfg_we) begin
        m_short = cfg_byte[7];
        m_idx = int'(cfg_byte[3:0]);
      end
      exp_q.push_back('{low: m_lfsr[0], tick: t});
    end
  end

  // Monitor: pop and compare away from the edge
  always @(negedge clk) begin
    if (rst) begin
      check(sample == 4'd0, "R1", sample, 0);
    end else if (exp_q.size() > 0) begin
      exp_t it;
      int e;
      it = exp_q.pop_front();
      e = (it.low || !len_active) ? 0 : int'(volume);
      check(int'(sample) == e, phase, sample, e);
      if (capturing && it.tick) obs_q.push_back(sample == 4'd0);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(posedge clk); #2;
    cfg_we = 1; cfg_byte = v;
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst = 1;
    cycles(3);
    rst = 0;
  endtask

  task automatic capture(int shifts);
    obs_q.delete();
    capturing = 1;
    while (obs_q.size() < shifts) @(negedge clk);
    capturing = 0;
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(195000 * 8);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cycles(4);
    rst = 0;
    // R1 / R5: long sequence from reset at the shortest interval
    phase = "R5";
    capture(32767 + 15);
    for (int k = 0; k < 15; k++)
      check(obs_q[k] == obs_q[k + 32767], "R5", obs_q[k + 32767], obs_q[k]);
    begin
      int run = 0;
      int worst = 0;
      foreach (obs_q[k]) begin
        if (!obs_q[k]) run++; else run = 0;
        if (run > worst) worst = run;
      end
      check(worst <= 14, "R5", worst, 14);
    end

    // R6: short sequence repeat length
    do_reset();
    phase = "R6";
    write_cfg(8'h80);
    cycles(8);
    capture(93 + 15);
    for (int k = 0; k < 15; k++)
      check(obs_q[k] == obs_q[k + 93], "R6", obs_q[k + 93], obs_q[k]);

    // R3 / R2: every table interval, with ignored bits 6:4 set
    phase = "R3";
    for (int i = 0; i < 16; i++) begin
      write_cfg(8'h70 | 8'(i));
      cycles(3 * tbl[i]);
    end

    // R8: period change mid-count takes effect at next reload
    phase = "R8";
    write_cfg(8'h05);
    cycles(40);
    write_cfg(8'h00);
    cycles(120);

    // R9 / R4: toggle mode between shifts
    phase = "R9";
    write_cfg(8'h83);
    cycles(17);
    write_cfg(8'h03);
    cycles(50);
    write_cfg(8'h81);
    cycles(70);

    // R7: gating by volume and length flag
    phase = "R7";
    write_cfg(8'h00);
    for (int v = 0; v < 16; v++) begin
      volume = 4'(v);
      cycles(5);
      len_active = 0;
      cycles(3);
      len_active = 1;
      cycles(3);
    end

    // R1: reset mid-run returns to known state
    phase = "R1";
    do_reset();
    cycles(30);

    summary();
  end
endmodule